// File: doc/BRIEF.md
# Ordered-Word Activation Lock

This block keeps a protected core inert until the right key has been entered. After every reset it sits in a locked condition. In that condition the core's functional outputs are replaced by a fixed safe value and the core enable is held low. The lock opens only when a fixed series of input words arrives on the word port, each word qualified by a valid strobe, in exactly the right order. A per-chip identifier can be read on a separate port in every state. The key holder reads that identifier while the part is still locked and returns the matching word series for that chip.

The controller has three states. LK_LOCKED is the reset state, and it carries a step index into the key and a count of failed words. LK_OPEN is the unlocked state; it passes the core outputs through. LK_BARRED is the lockout state; it is entered after too many wrong words. The transitions are as follows. ADVANCE keeps the state at LK_LOCKED and moves to the next step when a valid word matches the expected key word. RELEASE goes from LK_LOCKED to LK_OPEN when the final key word matches. RESTART keeps the state at LK_LOCKED and takes a wrong word back to step 0, or to step 1 when the wrong word equals the first key word. BAR goes from LK_LOCKED to LK_BARRED on the failure that brings the count up to the limit. Reset takes every state back to LK_LOCKED. Once the state is LK_OPEN or LK_BARRED, it holds there until the next reset. The chip identifier here comes from a behavioural stand-in that holds a parameter value.

Top module: `seq_unlock_ctrl`

## Requirements
- R1: Reset, applied from any state, leaves the block with only st_locked high, the step index at 0 and the failure count at 0. After reset the full key unlocks again, even if the block was in lockout before the reset.
- R2: The key is KEY_LEN words of WORD_W bits packed in KEY_SEQ. Word i sits at bits [i*WORD_W +: WORD_W], and word 0 must be applied first. By default the words are 16'hC3A5, 16'h0BEE, 16'h5A17 and 16'hD00D, in that order. Valid words matching every key word in order raise st_unlocked on the clock edge that takes the last word.
- R3: While locked, a valid word that does not match the expected key word resets the step index to 0. If that wrong word equals key word 0, the step index goes to 1 instead. A series with any one word wrong does not unlock.
- R4: Each wrong valid word counts one failure, and the count is cumulative across attempts. The MAX_FAILS-th failure (8 by default) moves the block to lockout on that same edge. In lockout, every word is ignored, including a full correct key, and only reset clears the lockout.
- R5: A word presented with in_valid low does not change the state, the step index or the failure count.
- R6: Once unlocked, the block stays unlocked until reset, and any further valid words are ignored.
- R7: Exactly one of st_locked, st_unlocked and st_lockout is high at all times.
- R8: Unless the block is unlocked, core_out equals SAFE_VALUE (all zeros by default) and core_en is low. When unlocked, core_en is high and core_out follows core_raw in the same cycle.
- R9: chip_id shows the CHIP_ID parameter (32'h5EC0_1D42 by default) in every state, including during reset and while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | WORD_W | Key word candidate |
| in_valid | input | 1 | Qualifies in_word for one clock |
| core_raw | input | CORE_W | Functional outputs of the protected core |
| core_out | output | CORE_W | Gated core outputs |
| core_en | output | 1 | Enable to the protected core |
| chip_id | output | ID_W | Per-chip identifier |
| st_locked | output | 1 | Locked status |
| st_unlocked | output | 1 | Unlocked status |
| st_lockout | output | 1 | Lockout status |

## Verification
The first pattern interleaves a correct prefix with a wrong word, which shows that a mismatch restarts the sequence instead of skipping over the bad word. The second places the first key word at a wrong step, which shows the restart going to step 1 rather than step 0; only three further words then unlock the block. Words held with the strobe low show that an unqualified word has no effect. A run of wrong words separates the last tolerated failure from the one that bars the block, and a correct key applied afterwards shows that lockout ignores it. Reset is applied from both the open state and the barred state, and a fresh unlock then shows that the step index and failure count were cleared.

// File: rtl/slk_pkg.sv
package slk_pkg;

    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_OPEN   = 2'd1,
        LK_BARRED = 2'd2
    } lk_state_e;

endpackage

// File: rtl/slk_id_src.sv
module slk_id_src #(
    parameter int          ID_W    = 32,
    parameter logic [ID_W-1:0] CHIP_ID = 32'h5EC0_1D42
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [ID_W-1:0] id_value
);
    // Behavioural stand-in for the identifier source: a register that
    // loads the parameter value at reset and then holds it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) id_value <= CHIP_ID;
        else        id_value <= id_value;
    end

    AST_ID_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        id_value == CHIP_ID); // R9
endmodule

// File: rtl/slk_seq_fsm.sv
module slk_seq_fsm
    import slk_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int KEY_LEN   = 4,
    parameter int MAX_FAILS = 8,
    parameter logic [KEY_LEN*WORD_W-1:0] KEY_SEQ = 64'hD00D_5A17_0BEE_C3A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              is_locked,
    output logic              is_open,
    output logic              is_barred
);
    localparam int STEP_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
    localparam int FAIL_W = $clog2(MAX_FAILS + 1);
    localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(KEY_LEN - 1);
    localparam logic [FAIL_W-1:0] FAIL_LIMIT = FAIL_W'(MAX_FAILS - 1);
    localparam logic [WORD_W-1:0] FIRST_WORD = KEY_SEQ[WORD_W-1:0];

    lk_state_e         state, state_n;
    logic [STEP_W-1:0] step, step_n;
    logic [FAIL_W-1:0] fails, fails_n;
    logic [WORD_W-1:0] want_word;

    assign want_word = KEY_SEQ[int'(step)*WORD_W +: WORD_W];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LK_LOCKED;
            step  <= '0;
            fails <= '0;
        end else begin
            state <= state_n;
            step  <= step_n;
            fails <= fails_n;
        end
    end

    // Transitions
    always_comb begin
        state_n = state;
        step_n  = step;
        fails_n = fails;
        unique case (state)
            LK_LOCKED: begin
                if (in_valid) begin
                    if (in_word == want_word) begin
                        if (step == LAST_STEP) begin      // RELEASE
                            state_n = LK_OPEN;
                            step_n  = '0;
                        end else begin                    // ADVANCE
                            step_n = step + STEP_W'(1);
                        end
                    end else begin
                        fails_n = fails + FAIL_W'(1);
                        if (fails == FAIL_LIMIT) begin    // BAR
                            state_n = LK_BARRED;
                            step_n  = '0;
                        end else if (in_word == FIRST_WORD && KEY_LEN > 1) begin
                            step_n = STEP_W'(1);          // RESTART at 1
                        end else begin
                            step_n = '0;                  // RESTART at 0
                        end
                    end
                end
            end
            LK_OPEN:   state_n = LK_OPEN;
            LK_BARRED: state_n = LK_BARRED;
            default:   state_n = LK_LOCKED;
        endcase
    end

    // Outputs
    always_comb begin
        is_locked = 1'b0;
        is_open   = 1'b0;
        is_barred = 1'b0;
        unique case (state)
            LK_OPEN:   is_open   = 1'b1;
            LK_BARRED: is_barred = 1'b1;
            default:   is_locked = 1'b1;
        endcase
    end

    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({is_locked, is_open, is_barred}) == 1); // R7
    AST_RESET_LOCKS: assert property (@(posedge clk)
        $rose(rst_n) |-> (state == LK_LOCKED && step == '0 && fails == '0)); // R1
    AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        is_open |=> is_open); // R6
    AST_BARRED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        is_barred |=> is_barred); // R4
    AST_FAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        is_locked |-> fails < FAIL_W'(MAX_FAILS)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_locked && !in_valid) |=> ($stable(step) && $stable(fails))); // R5
    AST_OPEN_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_open) |-> ($past(in_valid) && $past(step) == LAST_STEP
                            && $past(in_word) == KEY_SEQ[KEY_LEN*WORD_W-1 -: WORD_W])); // R2
endmodule

// File: rtl/slk_out_gate.sv
module slk_out_gate #(
    parameter int              CORE_W     = 8,
    parameter logic [CORE_W-1:0] SAFE_VALUE = '0
) (
    input  logic              open_i,
    input  logic [CORE_W-1:0] raw_i,
    output logic [CORE_W-1:0] gated_o,
    output logic              en_o
);
    always_comb begin
        en_o    = open_i;
        gated_o = open_i ? raw_i : SAFE_VALUE;
    end
endmodule

// File: rtl/seq_unlock_ctrl.sv
module seq_unlock_ctrl #(
    parameter int WORD_W    = 16,
    parameter int KEY_LEN   = 4,
    parameter int MAX_FAILS = 8,
    parameter int ID_W      = 32,
    parameter int CORE_W    = 8,
    parameter logic [KEY_LEN*WORD_W-1:0] KEY_SEQ    = 64'hD00D_5A17_0BEE_C3A5,
    parameter logic [ID_W-1:0]           CHIP_ID    = 32'h5EC0_1D42,
    parameter logic [CORE_W-1:0]         SAFE_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    input  logic [CORE_W-1:0] core_raw,
    output logic [CORE_W-1:0] core_out,
    output logic              core_en,
    output logic [ID_W-1:0]   chip_id,
    output logic              st_locked,
    output logic              st_unlocked,
    output logic              st_lockout
);
    slk_id_src #(.ID_W(ID_W), .CHIP_ID(CHIP_ID)) u_id (
        .clk      (clk),
        .rst_n    (rst_n),
        .id_value (chip_id)
    );

    slk_seq_fsm #(
        .WORD_W(WORD_W), .KEY_LEN(KEY_LEN),
        .MAX_FAILS(MAX_FAILS), .KEY_SEQ(KEY_SEQ)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_word   (in_word),
        .in_valid  (in_valid),
        .is_locked (st_locked),
        .is_open   (st_unlocked),
        .is_barred (st_lockout)
    );

    slk_out_gate #(.CORE_W(CORE_W), .SAFE_VALUE(SAFE_VALUE)) u_gate (
        .open_i  (st_unlocked),
        .raw_i   (core_raw),
        .gated_o (core_out),
        .en_o    (core_en)
    );

    AST_SHUT_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_locked || st_lockout) |-> (core_out == SAFE_VALUE && !core_en)); // R8
    AST_PASS_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_unlocked |-> (core_out == core_raw && core_en)); // R8
endmodule

// File: tb/test_seq_unlock_ctrl.sv
module test_seq_unlock_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_word = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  core_raw = 8'hA5;
    logic [7:0]  core_out;
    logic        core_en;
    logic [31:0] chip_id;
    logic        st_locked, st_unlocked, st_lockout;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [15:0] K0 = 16'hC3A5, K1 = 16'h0BEE, K2 = 16'h5A17, K3 = 16'hD00D;
    localparam logic [2:0] S_L = 3'b001, S_U = 3'b010, S_X = 3'b100;

    // {valid, word, expected {lockout, unlocked, locked}}
    localparam logic [19:0] VEC [13] = '{
        {1'b1, K0,       S_L},  // step 1
        {1'b1, K1,       S_L},  // step 2
        {1'b1, 16'h1111, S_L},  // R3 wrong word -> step 0, fail 1
        {1'b1, K0,       S_L},  // step 1
        {1'b0, K1,       S_L},  // R5 unqualified, ignored
        {1'b1, K1,       S_L},  // step 2
        {1'b1, K2,       S_L},  // step 3
        {1'b1, K0,       S_L},  // R3 wrong but first word -> step 1, fail 2
        {1'b1, K1,       S_L},  // step 2
        {1'b1, K2,       S_L},  // step 3
        {1'b1, K3,       S_U},  // R2 unlock
        {1'b1, 16'h1234, S_U},  // R6 ignored
        {1'b0, 16'h0000, S_U}   // R6 holds
    };

    seq_unlock_ctrl i_seq_unlock_ctrl (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .core_raw(core_raw), .core_out(core_out), .core_en(core_en),
        .chip_id(chip_id), .st_locked(st_locked), .st_unlocked(st_unlocked),
        .st_lockout(st_lockout)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] status();
        return {st_lockout, st_unlocked, st_locked};
    endfunction

    task automatic chk_state(input string req, input logic [2:0] exp);
        chk(req, {29'd0, status()}, {29'd0, exp});
        chk({req, "/R7"}, $countones(status()), 1);
        chk({req, "/R8 out"}, {24'd0, core_out}, (exp == S_U) ? {24'd0, core_raw} : 32'd0);
        chk({req, "/R8 en"}, {31'd0, core_en}, {31'd0, exp == S_U});
    endtask

    task automatic put(input logic v, input logic [15:0] w);
        @(negedge clk);
        in_valid = v;
        in_word  = w;
        @(posedge clk);
        #2;
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_state("R1 during reset", S_L);
        chk("R9 id in reset", chip_id, 32'h5EC0_1D42);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        do_reset();
        @(posedge clk); #2;
        chk_state("R1 after reset", S_L);
        chk("R9 id locked", chip_id, 32'h5EC0_1D42);

        for (int i = 0; i < 13; i++) begin
            put(VEC[i][19], VEC[i][18:3]);
            chk_state($sformatf("R2/R3 vector %0d", i), VEC[i][2:0]);
        end
        core_raw = 8'h3C;
        #1;
        chk_state("R8 pass-through follows raw", S_U);
        chk("R9 id unlocked", chip_id, 32'h5EC0_1D42);

        // R1: reset from unlocked re-locks
        do_reset();
        @(posedge clk); #2;
        chk_state("R1 relock from open", S_L);

        // R4: lockout after 8 cumulative failures
        for (int i = 0; i < 7; i++) put(1'b1, 16'h0000);
        chk_state("R4 seven failures still locked", S_L);
        put(1'b1, 16'h0000);
        chk_state("R4 eighth failure locks out", S_X);
        put(1'b1, K0); put(1'b1, K1); put(1'b1, K2); put(1'b1, K3);
        chk_state("R4 key ignored in lockout", S_X);
        chk("R9 id lockout", chip_id, 32'h5EC0_1D42);

        // R1: reset clears lockout and the count; key then unlocks
        do_reset();
        @(posedge clk); #2;
        chk_state("R1 relock from lockout", S_L);
        put(1'b1, K0); put(1'b1, K1); put(1'b1, K2);
        chk_state("R2 one word short stays locked", S_L);
        put(1'b1, K3);
        chk_state("R1 unlock after lockout reset", S_U);

        // R3: one wrong word in an otherwise correct series
        do_reset();
        @(posedge clk); #2;
        put(1'b1, K0); put(1'b1, K1); put(1'b1, 16'hBEEF); put(1'b1, K3);
        chk_state("R3 single wrong word no unlock", S_L);

        done = 1'b1;
        finish_run();
    end
endmodule